// File: doc/BRIEF.md
# Fairness-Aware DRAM Request Scheduler

This block chooses one request per DRAM cycle out of a shared request buffer that is filled by several hardware threads. Each buffer entry has a valid bit, the ID of the issuing thread, a target bank, a target row and an age. The age is a sequence number: a smaller value means an older request. In every cycle the block also receives a slowdown figure for each thread, a weight for each thread and a programmable unfairness threshold, alpha. It returns the buffer index of the winning entry. It also reports whether that entry hits the open row of its bank, and which arbitration mode was in force.

Each slowdown is multiplied by its thread's weight. Only threads that hold at least one valid entry are considered. The block finds the largest and the smallest of their weighted slowdowns. If the largest reaches alpha times the smallest, the block works in fairness mode. In that mode entries from the most-slowed thread win first, then entries that hit the open row, then the oldest entries. If the ratio is below alpha, the block works in throughput mode, where only the row-hit and age rules apply.

The block keeps one open-row register per bank. Every granted request leaves its row open in its bank for the decisions that follow. A valid request is always granted, even when nothing competes with it.

Top module: `fair_req_sched`

## Requirements
- R1: After reset every bank is closed. The first request to any bank is therefore reported as a miss (`grant_row_hit` = 0).
- R2: `grant_valid` is 1 exactly when at least one `req_valid` bit is set. `grant_idx` then names a valid entry.
- R3: In throughput mode (`fair_mode` = 0), an entry whose row equals the open row of its bank wins over any entry that misses.
- R4: Among entries of equal rank, the entry with the smallest age wins.
- R5: If rank and age are equal, the lowest buffer index wins.
- R6: A thread with no valid entry is left out of the largest and smallest slowdown, whatever its slowdown input holds.
- R7: `fair_mode` is 1 when weighted-max × 2^ALPHA_FRAC ≥ alpha × weighted-min, and 0 when it is below. Alpha is unsigned fixed point with ALPHA_FRAC fraction bits. With no valid entry, `fair_mode` is 0.
- R8: In fairness mode, the most-slowed thread ranks first, then row hit, then age.
- R9: The quantity compared is slowdown × weight. A higher weight raises a thread's standing.
- R10: A granted entry leaves its row open in its bank from the next cycle on. A later request to the same bank and row is then a hit.
- R11: An alpha larger than every ratio that occurs keeps the block in throughput mode.
- R12: If two threads share the largest weighted slowdown, the thread with the lowest ID counts as most slowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset; closes all banks |
| req_valid | input | NUM_ENTRIES | Entry holds a pending request |
| req_thread | input | NUM_ENTRIES*TID_W | Thread ID per entry; entry i at bits [i*TID_W +: TID_W] |
| req_bank | input | NUM_ENTRIES*BANK_W | Bank per entry, same packing |
| req_row | input | NUM_ENTRIES*ROW_W | Row per entry, same packing |
| req_age | input | NUM_ENTRIES*AGE_W | Sequence number per entry; smaller is older |
| thr_slowdown | input | NUM_THREADS*SLD_W | Slowdown per thread, unsigned |
| thr_weight | input | NUM_THREADS*WGT_W | Weight per thread, unsigned |
| alpha | input | ALPHA_W | Unfairness threshold, ALPHA_FRAC fraction bits |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | IDX_W | Buffer index of the granted entry |
| grant_row_hit | output | 1 | Granted entry hits its bank's open row |
| fair_mode | output | 1 | Fairness mode is in force this cycle |

## Verification
The main stimulus is a long random sweep over a small configuration. It uses four banks and four rows, so row hits, bank conflicts and equal ages all happen often. Slowdowns, weights and alpha are random, so both modes come up. A reference model in the bench predicts each cycle's winner, and comparing the model with the design separates errors in the hit/age order from errors in the mode decision. Directed cases isolate the remaining corners:
- all ages equal, which tests the lowest-index tie rule;
- an idle thread with a huge slowdown, which must be ignored;
- equal slowdowns that a weight alone must separate;
- a tie for the largest weighted slowdown;
- the maximum alpha;
- the first access to closed banks after reset.

// File: rtl/fs_pkg.sv
package fs_pkg;
   // Rank bits placed above the inverted age inside an arbitration key.
   localparam int RANK_BITS = 2;

   // Key layout, MSB first: favoured thread, row hit, inverted age.
   function automatic int key_width(input int age_w);
      return RANK_BITS + age_w;
   endfunction
endpackage

// File: rtl/fs_thread_stats.sv
module fs_thread_stats #(
   parameter int NUM_ENTRIES = 128,
   parameter int NUM_THREADS = 8,
   parameter int TID_W       = 3,
   parameter int SLD_W       = 12,
   parameter int WGT_W       = 4,
   parameter int ALPHA_W     = 12,
   parameter int ALPHA_FRAC  = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_ENTRIES-1:0]         req_valid,
   input  logic [NUM_ENTRIES*TID_W-1:0]   req_thread,
   input  logic [NUM_THREADS*SLD_W-1:0]   thr_slowdown,
   input  logic [NUM_THREADS*WGT_W-1:0]   thr_weight,
   input  logic [ALPHA_W-1:0]             alpha,
   output logic                           any_active,
   output logic                           fair_mode,
   output logic [TID_W-1:0]               top_tid
);
   localparam int PW = SLD_W + WGT_W;
   localparam int CW = PW + ALPHA_W;

   logic [NUM_THREADS-1:0] active;
   logic [PW-1:0]          wsd [NUM_THREADS];
   logic [PW-1:0]          hi_val, lo_val;
   logic [CW-1:0]          lhs, rhs;

   // Which threads own at least one pending entry.
   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_act
         logic [NUM_ENTRIES-1:0] own;
         for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_own
            assign own[i] = req_valid[i] &&
                            (req_thread[i*TID_W +: TID_W] == TID_W'(t));
         end
         assign active[t] = |own;
         assign wsd[t] = PW'(thr_slowdown[t*SLD_W +: SLD_W]) *
                         PW'(thr_weight[t*WGT_W +: WGT_W]);
      end
   endgenerate

   // Largest and smallest weighted slowdown among active threads;
   // strict compare keeps the lowest thread ID on a tie for the top.
   always_comb begin
      logic seen;
      seen   = 1'b0;
      hi_val = '0;
      lo_val = '1;
      top_tid = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (active[t]) begin
            if (!seen || wsd[t] > hi_val) begin
               hi_val  = wsd[t];
               top_tid = TID_W'(t);
            end
            if (!seen || wsd[t] < lo_val) lo_val = wsd[t];
            seen = 1'b1;
         end
      end
   end

   assign any_active = |active;
   // Ratio test by cross-multiplication: max / min >= alpha.
   assign lhs       = CW'(hi_val) << ALPHA_FRAC;
   assign rhs       = CW'(lo_val) * CW'(alpha);
   assign fair_mode = any_active && (lhs >= rhs);

   p_top_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_active |-> active[top_tid]);
   p_idle_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_valid) |-> !fair_mode);
endmodule

// File: rtl/fs_open_rows.sv
module fs_open_rows #(
   parameter int NUM_ENTRIES = 128,
   parameter int NUM_BANKS   = 8,
   parameter int BANK_W      = 3,
   parameter int ROW_W       = 14
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
   input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
   input  logic                          upd_en,
   input  logic [BANK_W-1:0]             upd_bank,
   input  logic [ROW_W-1:0]              upd_row,
   output logic [NUM_ENTRIES-1:0]        hit
);
   logic [NUM_BANKS-1:0] open_vld;
   logic [ROW_W-1:0]     open_row [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_vld[b] <= 1'b0;
               open_row[b] <= '0;
            end else if (upd_en && upd_bank == BANK_W'(b)) begin
               open_vld[b] <= 1'b1;
               open_row[b] <= upd_row;
            end
         end
      end
      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_hit
         logic [BANK_W-1:0] bk;
         assign bk     = req_bank[i*BANK_W +: BANK_W];
         assign hit[i] = open_vld[bk] &&
                         (open_row[bk] == req_row[i*ROW_W +: ROW_W]);
      end
   endgenerate

   p_row_opened_r10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> open_vld[$past(upd_bank)] &&
                 open_row[$past(upd_bank)] == $past(upd_row));
endmodule

// File: rtl/fs_pick_tree.sv
module fs_pick_tree #(
   parameter int N     = 128,
   parameter int KEY_W = 14,
   parameter int IDX_W = 7
) (
   input  logic [N-1:0]       vld,
   input  logic [N*KEY_W-1:0] keys,
   output logic               win_vld,
   output logic [IDX_W-1:0]   win_idx,
   output logic [KEY_W-1:0]   win_key
);
   localparam int P  = 1 << IDX_W;
   localparam int NK = KEY_W + 1;

   // Heap-ordered nodes: node k has children 2k and 2k+1, leaves at P+i.
   logic [NK-1:0]    nkey [1:2*P-1];
   logic [IDX_W-1:0] nidx [1:2*P-1];

   generate
      for (genvar i = 0; i < P; i++) begin : g_leaf
         if (i < N) begin : g_real
            assign nkey[P+i] = {vld[i], keys[i*KEY_W +: KEY_W]};
         end else begin : g_pad
            assign nkey[P+i] = '0;
         end
         assign nidx[P+i] = IDX_W'(i);
      end
      for (genvar k = 1; k < P; k++) begin : g_node
         // The right child wins only when strictly better: lower index on ties.
         logic take_r;
         assign take_r  = nkey[2*k+1] > nkey[2*k];
         assign nkey[k] = take_r ? nkey[2*k+1] : nkey[2*k];
         assign nidx[k] = take_r ? nidx[2*k+1] : nidx[2*k];
      end
   endgenerate

   assign win_vld = nkey[1][NK-1];
   assign win_key = nkey[1][KEY_W-1:0];
   assign win_idx = nidx[1];
endmodule

// File: rtl/fair_req_sched.sv
module fair_req_sched #(
   parameter int NUM_ENTRIES = 128,
   parameter int NUM_THREADS = 8,
   parameter int NUM_BANKS   = 8,
   parameter int ROW_W       = 14,
   parameter int AGE_W       = 12,
   parameter int SLD_W       = 12,
   parameter int WGT_W       = 4,
   parameter int ALPHA_W     = 12,
   parameter int ALPHA_FRAC  = 8,
   localparam int TID_W      = $clog2(NUM_THREADS),
   localparam int BANK_W     = $clog2(NUM_BANKS),
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_ENTRIES-1:0]           req_valid,
   input  logic [NUM_ENTRIES*TID_W-1:0]     req_thread,
   input  logic [NUM_ENTRIES*BANK_W-1:0]    req_bank,
   input  logic [NUM_ENTRIES*ROW_W-1:0]     req_row,
   input  logic [NUM_ENTRIES*AGE_W-1:0]     req_age,
   input  logic [NUM_THREADS*SLD_W-1:0]     thr_slowdown,
   input  logic [NUM_THREADS*WGT_W-1:0]     thr_weight,
   input  logic [ALPHA_W-1:0]               alpha,
   output logic                             grant_valid,
   output logic [IDX_W-1:0]                 grant_idx,
   output logic                             grant_row_hit,
   output logic                             fair_mode
);
   import fs_pkg::*;
   localparam int KEY_W = key_width(AGE_W);

   initial begin
      assert (NUM_ENTRIES >= 2) else $error("NUM_ENTRIES must be at least 2");
      assert (NUM_THREADS >= 2) else $error("NUM_THREADS must be at least 2");
      assert (NUM_BANKS >= 2)   else $error("NUM_BANKS must be at least 2");
      assert (ALPHA_FRAC <= ALPHA_W) else $error("ALPHA_FRAC exceeds ALPHA_W");
   end

   logic                     any_active;
   logic [TID_W-1:0]         top_tid;
   logic [NUM_ENTRIES-1:0]   hit;
   logic [NUM_ENTRIES*KEY_W-1:0] keys;
   logic [KEY_W-1:0]         win_key;

   fs_thread_stats #(
      .NUM_ENTRIES(NUM_ENTRIES), .NUM_THREADS(NUM_THREADS), .TID_W(TID_W),
      .SLD_W(SLD_W), .WGT_W(WGT_W), .ALPHA_W(ALPHA_W), .ALPHA_FRAC(ALPHA_FRAC)
   ) u_stats (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
      .thr_slowdown(thr_slowdown), .thr_weight(thr_weight), .alpha(alpha),
      .any_active(any_active), .fair_mode(fair_mode), .top_tid(top_tid)
   );

   fs_open_rows #(
      .NUM_ENTRIES(NUM_ENTRIES), .NUM_BANKS(NUM_BANKS),
      .BANK_W(BANK_W), .ROW_W(ROW_W)
   ) u_rows (
      .clk(clk), .rst_n(rst_n), .req_bank(req_bank), .req_row(req_row),
      .upd_en(grant_valid),
      .upd_bank(req_bank[grant_idx*BANK_W +: BANK_W]),
      .upd_row(req_row[grant_idx*ROW_W +: ROW_W]),
      .hit(hit)
   );

   // Per-entry key: favoured-thread bit (fairness mode only), row hit, ~age.
   generate
      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_key
         logic fav;
         assign fav = fair_mode && (req_thread[i*TID_W +: TID_W] == top_tid);
         assign keys[i*KEY_W +: KEY_W] = {fav, hit[i], ~req_age[i*AGE_W +: AGE_W]};
      end
   endgenerate

   fs_pick_tree #(.N(NUM_ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_pick (
      .vld(req_valid), .keys(keys),
      .win_vld(grant_valid), .win_idx(grant_idx), .win_key(win_key)
   );

   assign grant_row_hit = win_key[AGE_W];

   p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == (|req_valid));
   p_grant_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> req_valid[grant_idx]);
   p_hit_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !fair_mode && !grant_row_hit) |-> !(|(req_valid & hit)));
   p_fav_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && fair_mode) |->
         req_thread[grant_idx*TID_W +: TID_W] == top_tid);
   p_mode_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fair_mode |-> any_active);
endmodule

// File: tb/fair_req_sched_tb.sv
module fair_req_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8, T = 4, B = 4, RW = 4, AW = 6;
   localparam int SW = 8, WW = 4, ALW = 10, AF = 6;
   localparam int TW = 2, BW = 2, IW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0]     req_valid;
   logic [N*TW-1:0]  req_thread;
   logic [N*BW-1:0]  req_bank;
   logic [N*RW-1:0]  req_row;
   logic [N*AW-1:0]  req_age;
   logic [T*SW-1:0]  thr_slowdown;
   logic [T*WW-1:0]  thr_weight;
   logic [ALW-1:0]   alpha;
   logic             grant_valid, grant_row_hit, fair_mode;
   logic [IW-1:0]    grant_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   fair_req_sched #(.NUM_ENTRIES(N), .NUM_THREADS(T), .NUM_BANKS(B), .ROW_W(RW),
      .AGE_W(AW), .SLD_W(SW), .WGT_W(WW), .ALPHA_W(ALW), .ALPHA_FRAC(AF)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
      .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
      .thr_slowdown(thr_slowdown), .thr_weight(thr_weight), .alpha(alpha),
      .grant_valid(grant_valid), .grant_idx(grant_idx),
      .grant_row_hit(grant_row_hit), .fair_mode(fair_mode));

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   int v[N], th[N], bk[N], rw[N], ag[N], sl[T], wt[T], al;
   bit ob_v[B];
   int ob_r[B];
   bit e_valid, e_hit, e_fair;
   int e_idx, e_top;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive();
      for (int i = 0; i < N; i++) begin
         req_valid[i] = v[i][0];
         req_thread[i*TW +: TW] = TW'(th[i]);
         req_bank[i*BW +: BW]   = BW'(bk[i]);
         req_row[i*RW +: RW]    = RW'(rw[i]);
         req_age[i*AW +: AW]    = AW'(ag[i]);
      end
      for (int t = 0; t < T; t++) begin
         thr_slowdown[t*SW +: SW] = SW'(sl[t]);
         thr_weight[t*WW +: WW]   = WW'(wt[t]);
      end
      alpha = ALW'(al);
   endtask

   // Reference prediction from the requirement text.
   task automatic predict();
      bit act[T];
      bit seen = 0;
      int mx = 0, mn = 0, bf = 0, bh = 0, ba = 0;
      for (int t = 0; t < T; t++) act[t] = 0;
      for (int i = 0; i < N; i++) if (v[i] != 0) act[th[i]] = 1;
      e_top = 0;
      for (int t = 0; t < T; t++) if (act[t]) begin
         int w = sl[t] * wt[t];
         if (!seen) begin mx = w; mn = w; e_top = t; end
         else begin
            if (w > mx) begin mx = w; e_top = t; end
            if (w < mn) mn = w;
         end
         seen = 1;
      end
      e_fair = seen && ((mx * (1 << AF)) >= (mn * al));
      e_valid = 0; e_idx = 0; e_hit = 0;
      for (int i = 0; i < N; i++) if (v[i] != 0) begin
         int f = (e_fair && th[i] == e_top) ? 1 : 0;
         int h = (ob_v[bk[i]] && ob_r[bk[i]] == rw[i]) ? 1 : 0;
         bit better;
         if (!e_valid) better = 1;
         else if (f != bf) better = f > bf;
         else if (h != bh) better = h > bh;
         else better = ag[i] < ba;
         if (better) begin
            e_valid = 1; e_idx = i; bf = f; bh = h; ba = ag[i];
         end
      end
      e_hit = bh[0];
   endtask

   // Drive at the falling edge, compare, then let the rising edge commit.
   task automatic step(input string tag);
      @(negedge clk);
      drive();
      predict();
      #1;
      check({tag, " R2 grant_valid"}, int'(grant_valid), int'(e_valid));
      check({tag, " R7 fair_mode"}, int'(fair_mode), int'(e_fair));
      if (e_valid) begin
         check({tag, " R3/R4/R8 grant_idx"}, int'(grant_idx), e_idx);
         check({tag, " R10 grant_row_hit"}, int'(grant_row_hit), int'(e_hit));
         ob_v[bk[e_idx]] = 1;
         ob_r[bk[e_idx]] = rw[e_idx];
      end
   endtask

   task automatic clear();
      for (int i = 0; i < N; i++) begin v[i] = 0; th[i] = 0; bk[i] = 0; rw[i] = 0; ag[i] = 0; end
      for (int t = 0; t < T; t++) begin sl[t] = 16; wt[t] = 1; end
      al = 1023;
   endtask

   initial begin
      for (int b = 0; b < B; b++) begin ob_v[b] = 0; ob_r[b] = 0; end
      clear();
      drive();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset no grant", int'(grant_valid), 0);

      // R1/R5: closed banks, all equal entries -> index 0, miss.
      for (int i = 0; i < N; i++) v[i] = 1;
      step("R1/R5 first");
      check("R1 miss after reset", int'(grant_row_hit), 0);
      check("R5 lowest index", int'(grant_idx), 0);
      // R10: same bank/row is now open.
      step("R10 reopen");
      check("R10 hit next cycle", int'(grant_row_hit), 1);

      // R6: idle thread 3 with huge slowdown must not force fairness.
      clear();
      v[0] = 1; th[0] = 0; v[1] = 1; th[1] = 1; sl[3] = 255; al = 128;
      step("R6 idle");
      check("R6 idle thread ignored", int'(fair_mode), 0);

      // R9: equal slowdowns, weight 4 on thread 1 -> ratio 4 >= 2.0.
      clear();
      v[0] = 1; th[0] = 0; ag[0] = 1; v[1] = 1; th[1] = 1; ag[1] = 9;
      wt[1] = 4; al = 128;
      step("R9 weight");
      check("R9 weighted thread wins", int'(grant_idx), 1);

      // R12: equal weighted slowdowns, alpha 1.0 -> fair, thread 1 beats 2.
      clear();
      v[0] = 1; th[0] = 2; ag[0] = 0; v[1] = 1; th[1] = 1; ag[1] = 5;
      al = 64;
      step("R12 tie");
      check("R12 lowest tid favoured", int'(grant_idx), 1);

      // R11: maximum alpha with ratio 15 stays in throughput mode.
      clear();
      v[0] = 1; th[0] = 0; v[1] = 1; th[1] = 1; sl[0] = 15; sl[1] = 1;
      step("R11 big alpha");
      check("R11 throughput kept", int'(fair_mode), 0);

      // Random sweep over all rules.
      for (int k = 0; k < 3000; k++) begin
         for (int i = 0; i < N; i++) begin
            v[i]  = ($urandom % 3 != 0) ? 1 : 0;
            th[i] = $urandom % T;
            bk[i] = $urandom % B;
            rw[i] = $urandom % 4;
            ag[i] = $urandom % 16;
         end
         for (int t = 0; t < T; t++) begin
            sl[t] = $urandom % 256;
            wt[t] = 1 + $urandom % 15;
         end
         al = (k % 5 == 0) ? 1023 : $urandom % 400;
         step("sweep");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R2: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule